// File: doc/BRIEF.md
# Four-Channel Request Priority Resolver

This block picks one of four transfer request lines and grants it for a single transfer cycle. A channel competes only when its request line and its enable bit are both high. The decision is not taken continuously. It is taken on the clock edge where a decision strobe is high and no grant is currently held. The result is registered and held until an end-of-cycle strobe releases it.

A mode input selects the priority order. In fixed order, channel 0 always wins over 1, 1 over 2, and 2 over 3. In rotating order, the channel that was just serviced falls to the bottom of the order, and the other channels each move up one place without changing their relative order. After reset, the rotating order is 0, 1, 2, 3. Any decision taken in fixed mode also returns the order to 0, 1, 2, 3.

The grant is presented three ways: as a one-hot vector, as an encoded index and as a valid flag. Address generation, bus timing and register programming are handled outside this block.

Top module: `prio_resolver_4ch`

## Requirements
- R1: After reset, gnt_valid_o is 0, gnt_o is 0 and gnt_idx_o is 0, and the rotating order is 0,1,2,3 (channel 0 highest). While gnt_valid_o is 0, gnt_o and gnt_idx_o stay 0.
- R2: Only a channel whose req_i bit and en_i bit are both 1 at the decision edge can be granted. When gnt_valid_o is 1, gnt_o has exactly one bit set, at bit position gnt_idx_o.
- R3: A decision taken with rot_mode_i=0 grants the lowest-numbered eligible channel.
- R4: A decision taken with rot_mode_i=1 uses the current order. Once a grant to channel k made in rotating mode is released by done_i, the order becomes k+1, k+2, … (mod 4), with k lowest.
- R5: A decision is taken on the rising clock edge where decide_i=1 and gnt_valid_o=0. The outputs show the result from the cycle after that edge. Between decisions, changes on req_i and en_i do not alter the outputs.
- R6: If no channel is eligible at a decision edge, gnt_valid_o stays 0 and the rotating order is left unchanged.
- R7: An edge with done_i=1 while gnt_valid_o=1 clears the grant on the next cycle. The order advances only when that grant was decided in rotating mode.
- R8: An edge with decide_i=1 while a grant is held has no effect: the held grant is kept unchanged.
- R9: rot_mode_i is sampled only at decision edges. A decision in fixed mode resets the rotating order to 0,1,2,3.
- R10: done_i while no grant is held has no effect on the outputs or on the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Request line per channel |
| en_i | input | 4 | Enable bit per channel |
| rot_mode_i | input | 1 | 1 = rotating order, 0 = fixed order |
| decide_i | input | 1 | Decision-point strobe |
| done_i | input | 1 | End-of-serviced-cycle strobe |
| gnt_o | output | 4 | One-hot grant |
| gnt_idx_o | output | 2 | Index of the granted channel |
| gnt_valid_o | output | 1 | A grant is held |

## Verification
The assertions check properties that must hold on every cycle:
- The idle outputs are zero.
- The grant is one-hot and matches the encoded index.
- Every new grant lands on a channel that was eligible one edge earlier.
- A fixed-mode decision picks the lowest eligible bit.
- A held grant does not move, whether req_i changes or a decision strobe arrives.
- done_i clears the grant, and a decision with no eligible channel produces no grant.

The rotation sequence depends on history, so only the bench scenarios can show it. These scenarios cover:
- Walking the order through a full round.
- Sparse request patterns after a given channel has been serviced.
- The order being left alone when no channel is eligible, and when done_i arrives with no grant held.
- The order being reset by a fixed-mode decision.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
  typedef enum logic {
    ORDER_FIXED  = 1'b0,
    ORDER_ROTATE = 1'b1
  } order_mode_e;
endpackage

// File: rtl/prio_order_ptr.sv
// Holds the channel index that currently has top priority.
module prio_order_ptr #(
  parameter int N_CH  = 4,
  parameter int IDX_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] served_i,
  output logic [IDX_W-1:0] top_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CH - 1);

  logic [IDX_W-1:0] top_q;
  logic [IDX_W-1:0] next_after_served;

  // The channel after the one just served gets top priority.
  always_comb begin
    if (served_i == LAST) next_after_served = '0;
    else                  next_after_served = served_i + IDX_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      top_q <= '0;
    else if (clear_i) top_q <= '0;
    else if (adv_i)   top_q <= next_after_served;
  end

  assign top_o = top_q;
endmodule

// File: rtl/prio_pick.sv
// Finds the first eligible channel, scanning upward from base_i with wrap-around.
module prio_pick #(
  parameter int N_CH  = 4,
  parameter int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  elig_i,
  input  logic [IDX_W-1:0] base_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N_CH; k++) begin
      int unsigned c;
      c = (int'(base_i) + k) % N_CH;
      if (!hit_o && elig_i[c]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/prio_grant_reg.sv
// Grant holding register with one-hot decode.
module prio_grant_reg #(
  parameter int N_CH  = 4,
  parameter int IDX_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] pick_i,
  input  logic             rot_i,
  input  logic             release_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             rot_o,
  output logic [N_CH-1:0]  onehot_o
);
  logic             valid_q;
  logic [IDX_W-1:0] idx_q;
  logic             rot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      rot_q   <= 1'b0;
    end else if (take_i) begin
      valid_q <= hit_i;
      idx_q   <= hit_i ? pick_i : '0;
      rot_q   <= rot_i;
    end else if (release_i) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_dec
    assign onehot_o[g] = valid_q && (idx_q == IDX_W'(g));
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;
  assign rot_o   = rot_q;
endmodule

// File: rtl/prio_resolver_4ch.sv
module prio_resolver_4ch
  import prio_res_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int IDX_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  req_i,
  input  logic [N_CH-1:0]  en_i,
  input  logic             rot_mode_i,
  input  logic             decide_i,
  input  logic             done_i,
  output logic [N_CH-1:0]  gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o,
  output logic             gnt_valid_o
);
  order_mode_e      mode;
  logic [N_CH-1:0]  elig;
  logic [IDX_W-1:0] top;
  logic [IDX_W-1:0] base;
  logic             hit;
  logic [IDX_W-1:0] pick;
  logic             take;
  logic             held_rot;
  logic             release_now;

  assign mode        = order_mode_e'(rot_mode_i);
  assign elig        = req_i & en_i;
  assign take        = decide_i && !gnt_valid_o;
  assign release_now = done_i && gnt_valid_o;
  assign base        = (mode == ORDER_ROTATE) ? top : '0;

  prio_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_pick (
    .elig_i (elig),
    .base_i (base),
    .hit_o  (hit),
    .idx_o  (pick)
  );

  prio_order_ptr #(.N_CH(N_CH), .IDX_W(IDX_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (take && (mode == ORDER_FIXED)),
    .adv_i    (release_now && held_rot),
    .served_i (gnt_idx_o),
    .top_o    (top)
  );

  prio_grant_reg #(.N_CH(N_CH), .IDX_W(IDX_W)) u_gnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .hit_i     (hit),
    .pick_i    (pick),
    .rot_i     (mode == ORDER_ROTATE),
    .release_i (release_now),
    .valid_o   (gnt_valid_o),
    .idx_o     (gnt_idx_o),
    .rot_o     (held_rot),
    .onehot_o  (gnt_o)
  );
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int N_CH  = 4,
  parameter int IDX_W = $clog2(N_CH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CH-1:0]  req_i,
  input logic [N_CH-1:0]  en_i,
  input logic             rot_mode_i,
  input logic             decide_i,
  input logic             done_i,
  input logic [N_CH-1:0]  gnt_o,
  input logic [IDX_W-1:0] gnt_idx_o,
  input logic             gnt_valid_o
);
  logic [N_CH-1:0] elig;
  logic [N_CH-1:0] lowest;
  assign elig   = req_i & en_i;
  assign lowest = elig & (~elig + N_CH'(1));

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_valid_o |-> (gnt_o == '0 && gnt_idx_o == '0));

  a_r2_onehot_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> ($onehot(gnt_o) && gnt_o[gnt_idx_o]));

  a_r2_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_valid_o) |-> (($past(elig) >> gnt_idx_o) & N_CH'(1)) != '0);

  a_r3_fixed_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && !gnt_valid_o && !rot_mode_i && elig != '0) |=> (gnt_valid_o && gnt_o == $past(lowest)));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !done_i) |=> (gnt_valid_o && $stable(gnt_o) && $stable(gnt_idx_o)));

  a_r6_no_elig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && !gnt_valid_o && elig == '0) |=> !gnt_valid_o);

  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && done_i) |=> !gnt_valid_o);

  a_r10_idle_no_decide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o && !decide_i) |=> !gnt_valid_o);
endmodule

bind prio_resolver_4ch prio_resolver_chk #(.N_CH(N_CH), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .en_i        (en_i),
  .rot_mode_i  (rot_mode_i),
  .decide_i    (decide_i),
  .done_i      (done_i),
  .gnt_o       (gnt_o),
  .gnt_idx_o   (gnt_idx_o),
  .gnt_valid_o (gnt_valid_o)
);

// File: tb/prio_resolver_4ch_tb.sv
`timescale 1ns/1ps
module prio_resolver_4ch_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic [3:0] en_i = '0;
  logic       rot_mode_i = 1'b0;
  logic       decide_i = 1'b0;
  logic       done_i = 1'b0;
  logic [3:0] gnt_o;
  logic [1:0] gnt_idx_o;
  logic       gnt_valid_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  prio_resolver_4ch u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .en_i(en_i),
    .rot_mode_i(rot_mode_i), .decide_i(decide_i), .done_i(done_i),
    .gnt_o(gnt_o), .gnt_idx_o(gnt_idx_o), .gnt_valid_o(gnt_valid_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic chk_grant(input string tag, input bit v, input int idx);
    check({tag, " valid"}, int'(gnt_valid_o), int'(v));
    if (v) begin
      check({tag, " idx"}, int'(gnt_idx_o), idx);
      check({tag, " onehot"}, int'(gnt_o), 1 << idx);
    end else begin
      check({tag, " gnt"}, int'(gnt_o), 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = '0; en_i = '0; decide_i = 0; done_i = 0; rot_mode_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // Decision edge happens between the two negedges; outputs are sampled after it.
  task automatic decide(input logic [3:0] rq, input logic [3:0] en, input bit rot);
    req_i = rq; en_i = en; rot_mode_i = rot; decide_i = 1'b1;
    @(negedge clk_i);
    decide_i = 1'b0;
  endtask

  task automatic finish_cycle();
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  task automatic serve(input string tag, input logic [3:0] rq, input bit rot, input int exp_idx);
    decide(rq, 4'hF, rot);
    chk_grant(tag, 1'b1, exp_idx);
    finish_cycle();
    chk_grant({tag, " released"}, 1'b0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk_grant("R1 reset", 1'b0, 0);
    check("R1 reset idx", int'(gnt_idx_o), 0);
    serve("R1 rot starts at 0", 4'hF, 1'b1, 0);
  endtask

  task automatic t_fixed();
    do_reset();
    serve("R3 fixed 1110", 4'b1110, 1'b0, 1);
    serve("R3 fixed no rotation", 4'b1110, 1'b0, 1);
    serve("R3 fixed 1000", 4'b1000, 1'b0, 3);
    decide(4'b1111, 4'b1100, 1'b0);
    chk_grant("R2 enable mask", 1'b1, 2);
    finish_cycle();
    decide(4'b1111, 4'b0000, 1'b0);
    chk_grant("R2 all disabled", 1'b0, 0);
  endtask

  task automatic t_rotate();
    do_reset();
    serve("R4 round 0", 4'hF, 1'b1, 0);
    serve("R4 round 1", 4'hF, 1'b1, 1);
    serve("R4 round 2", 4'hF, 1'b1, 2);
    serve("R4 round 3", 4'hF, 1'b1, 3);
    serve("R4 wrap 0", 4'hF, 1'b1, 0);
    serve("R4 sparse 1001 after 0", 4'b1001, 1'b1, 3);
    serve("R4 sparse 1001 after 3", 4'b1001, 1'b1, 0);
    serve("R4 sparse 0101 after 0", 4'b0101, 1'b1, 2);
  endtask

  task automatic t_none();
    do_reset();
    serve("R6 prep", 4'hF, 1'b1, 0);          // order now 1,2,3,0
    decide(4'b0000, 4'hF, 1'b1);
    chk_grant("R6 no eligible", 1'b0, 0);
    decide(4'b0001, 4'b0000, 1'b1);
    chk_grant("R6 masked only", 1'b0, 0);
    serve("R6 order kept", 4'hF, 1'b1, 1);
  endtask

  task automatic t_hold();
    do_reset();
    req_i = 4'b0100; en_i = 4'hF; rot_mode_i = 1'b0;
    @(negedge clk_i);
    chk_grant("R5 no decide no grant", 1'b0, 0);
    decide(4'b0100, 4'hF, 1'b0);
    chk_grant("R5 one cycle after decide", 1'b1, 2);
    req_i = 4'b0001;
    @(negedge clk_i);
    chk_grant("R5 req change held", 1'b1, 2);
    decide(4'b0001, 4'hF, 1'b0);
    chk_grant("R8 decide while held", 1'b1, 2);
    @(negedge clk_i);
    chk_grant("R8 still held", 1'b1, 2);
    finish_cycle();
    chk_grant("R7 done clears", 1'b0, 0);
  endtask

  task automatic t_idle_done();
    do_reset();
    serve("R10 prep", 4'hF, 1'b1, 0);         // order 1,2,3,0
    finish_cycle();
    chk_grant("R10 idle done outputs", 1'b0, 0);
    finish_cycle();
    serve("R10 order unchanged", 4'hF, 1'b1, 1);
  endtask

  task automatic t_mode_switch();
    do_reset();
    serve("R9 prep a", 4'hF, 1'b1, 0);
    serve("R9 prep b", 4'hF, 1'b1, 1);        // order 2,3,0,1
    decide(4'hF, 4'hF, 1'b1);
    rot_mode_i = 1'b0;                        // change between decisions: no effect
    @(negedge clk_i);
    chk_grant("R9 mode sampled at decide", 1'b1, 2);
    finish_cycle();                           // rotating grant -> order 3,0,1,2
    serve("R9 fixed decision", 4'hF, 1'b0, 0);
    serve("R7 fixed grant no advance / R9 order reset", 4'hF, 1'b1, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fixed();
        t_rotate();
        t_none();
        t_hold();
        t_idle_done();
        t_mode_switch();
      end
      begin
        repeat (20000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule